// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

This block is a synthesizable functional model of a word-organised static memory with two independent byte lanes. Five active-low controls (chip select, output enable, write enable, lower-byte enable and upper-byte enable) select one of four modes: standby, outputs off, read and byte-masked write. The bidirectional data bus is split into a data-in bus, a data-out bus and one drive flag per byte lane. A surrounding level can build tristate buffers from these signals, or an FPGA design can use the model internally with no tristate at all.

The storage is sampled on a clock: a write strobe that is active at a rising edge of `clk_i` stores the enabled lanes. Reads are combinational from the addressed word. The full-size configuration is `ADDR_W = 15`, which gives 32,768 words of 16 bits. The default is smaller so that elaboration stays light. Stored contents are not reset and are undefined until they are written. The active-low asynchronous reset only holds the model idle: no lane drives and no write is accepted.

Top module: `bytelane_sram`

## Requirements
- R1: While `rst_ni` is low, both drive flags are 0 and no clock edge changes stored data.
- R2: With `cs_ni` high, both drive flags are 0 and no write takes place, whatever the other controls are.
- R3: With `cs_ni` low and `we_ni` high, both drive flags are 0 if `oe_ni` is high or if both byte enables are high.
- R4: In a read (`cs_ni`=0, `we_ni`=1, `oe_ni`=0), `drive_lo_o` is 1 exactly when `lbe_ni` is 0 and `drive_hi_o` is 1 exactly when `ube_ni` is 0. Bits [7:0] of `rdata_o` carry the lower lane and bits [15:8] carry the upper lane of the addressed word. A lane that is not driven reads as zero.
- R5: At a rising clock edge with `cs_ni`=0 and `we_ni`=0, each lane whose byte enable is 0 stores its slice of `wdata_i` (lower lane [7:0], upper lane [15:8]) at `addr_i`. The value of `oe_ni` does not matter.
- R6: In a write, a lane whose byte enable is high keeps its stored value, and words at other addresses are unchanged.
- R7: With `we_ni` low and both byte enables high, no write strobe exists: nothing is stored and neither lane drives.
- R8: While `cs_ni` and `we_ni` are both low, both drive flags are 0, including when `oe_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock for the write strobe |
| rst_ni | input | 1 | Active-low asynchronous reset; holds the model idle |
| addr_i | input | ADDR_W | Word address |
| cs_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| lbe_ni | input | 1 | Lower byte lane enable, active low |
| ube_ni | input | 1 | Upper byte lane enable, active low |
| wdata_i | input | 16 | Write data, bits [7:0] lower lane |
| rdata_o | output | 16 | Read data; an undriven lane reads zero |
| drive_lo_o | output | 1 | Lower lane output enable for an external tristate |
| drive_hi_o | output | 1 | Upper lane output enable for an external tristate |

## Verification
The hardest case to reach is a write attempt that must leave storage unchanged: a clock edge with write enable low while the model is held in reset, while chip select is high, or while both byte enables are high. None of these cases changes an output directly. The bench first stores a known word at the target address. It then applies the blocked write with different data across a clock edge and reads the address back with both lanes enabled, so that a missing guard appears as changed read data.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_OUTOFF  = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } bsram_mode_e;
endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
  import bsram_pkg::*;
#(
  parameter int NUM_LANES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 oe_ni,
  input  logic                 we_ni,
  input  logic [NUM_LANES-1:0] ben_ni,
  output logic [NUM_LANES-1:0] wr_lane_o,
  output logic [NUM_LANES-1:0] rd_lane_o
);
  bsram_mode_e mode;
  logic        any_lane;

  assign any_lane = ~&ben_ni;

  always_comb begin
    if (!rst_ni || cs_ni)             mode = MODE_STANDBY;
    else if (!we_ni && any_lane)      mode = MODE_WRITE;
    else if (we_ni && !oe_ni && any_lane) mode = MODE_READ;
    else                              mode = MODE_OUTOFF;
  end

  always_comb begin
    wr_lane_o = '0;
    rd_lane_o = '0;
    case (mode)
      MODE_WRITE: wr_lane_o = ~ben_ni;
      MODE_READ:  rd_lane_o = ~ben_ni;
      default: ;
    endcase
  end

  a_r2_standby_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (wr_lane_o == '0 && rd_lane_o == '0));
  a_r3_outoff_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && we_ni && (oe_ni || &ben_ni)) |-> rd_lane_o == '0);
  a_r7_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&ben_ni) |-> (wr_lane_o == '0 && rd_lane_o == '0));
  a_r8_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !we_ni) |-> rd_lane_o == '0);
  a_r5_lanes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|wr_lane_o) && (|rd_lane_o)));
endmodule

// File: rtl/bsram_lane.sv
module bsram_lane #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o
);
  localparam int Depth = 1 << ADDR_W;

  logic [LANE_W-1:0] mem_q [Depth];

  // storage is deliberately not reset
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

  a_r5_lane_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(addr_i)] === $past(wdata_i));
  a_r6_lane_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> mem_q[$past(addr_i)] === $past(mem_q[addr_i]));
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                cs_ni,
  input  logic                oe_ni,
  input  logic                we_ni,
  input  logic                lbe_ni,
  input  logic                ube_ni,
  input  logic [2*LANE_W-1:0] wdata_i,
  output logic [2*LANE_W-1:0] rdata_o,
  output logic                drive_lo_o,
  output logic                drive_hi_o
);
  localparam int NumLanes = 2;

  logic [NumLanes-1:0] ben_n;
  logic [NumLanes-1:0] wr_lane;
  logic [NumLanes-1:0] rd_lane;

  assign ben_n = {ube_ni, lbe_ni};

  bsram_decode #(.NUM_LANES(NumLanes)) u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .oe_ni     (oe_ni),
    .we_ni     (we_ni),
    .ben_ni    (ben_n),
    .wr_lane_o (wr_lane),
    .rd_lane_o (rd_lane)
  );

  for (genvar g = 0; g < NumLanes; g++) begin : g_lane
    logic [LANE_W-1:0] lane_rd;
    bsram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .addr_i  (addr_i),
      .wr_en_i (wr_lane[g]),
      .wdata_i (wdata_i[g*LANE_W +: LANE_W]),
      .rdata_o (lane_rd)
    );
    assign rdata_o[g*LANE_W +: LANE_W] = rd_lane[g] ? lane_rd : '0;
  end

  assign drive_lo_o = rd_lane[0];
  assign drive_hi_o = rd_lane[1];

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!drive_lo_o && !drive_hi_o));
  a_r4_lo_follows_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_lo_o |-> (!cs_ni && we_ni && !oe_ni && !lbe_ni));
  a_r4_hi_follows_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_hi_o |-> (!cs_ni && we_ni && !oe_ni && !ube_ni));
  a_r4_undriven_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drive_lo_o |-> rdata_o[LANE_W-1:0] == '0) and
    (!drive_hi_o |-> rdata_o[2*LANE_W-1:LANE_W] == '0));
endmodule

// File: tb/sim_bytelane_sram.sv
module sim_bytelane_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, lbe_n = 1'b1, ube_n = 1'b1;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic          drv_lo, drv_hi;

  int n_checks = 0;
  int n_fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bytelane_sram #(.ADDR_W(AW), .LANE_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .cs_ni(cs_n), .oe_ni(oe_n),
    .we_ni(we_n), .lbe_ni(lbe_n), .ube_ni(ube_n), .wdata_i(wdata),
    .rdata_o(rdata), .drive_lo_o(drv_lo), .drive_hi_o(drv_hi)
  );

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; lbe_n = 1'b1; ube_n = 1'b1;
  endtask

  // one write across one rising edge; flags checked mid-write
  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d,
                    input logic cs, input logic oe, input logic lb, input logic ub,
                    input string req);
    @(negedge clk);
    addr = a; wdata = d; cs_n = cs; oe_n = oe; lbe_n = lb; ube_n = ub; we_n = 1'b0;
    #1 check(req, {drv_hi, drv_lo, 16'h0}, 18'h0);
    @(posedge clk);
    idle();
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic oe, input logic lb, input logic ub,
                    input logic [17:0] exp, input string req);
    @(negedge clk);
    addr = a; cs_n = 1'b0; we_n = 1'b1; oe_n = oe; lbe_n = lb; ube_n = ub;
    #1 check(req, {drv_hi, drv_lo, rdata}, exp);
    idle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    cs_n = 1'b0; oe_n = 1'b0; lbe_n = 1'b0; ube_n = 1'b0;
    #1 check("R1 flags in reset", {drv_hi, drv_lo, rdata}, 18'h0);
    idle();
    rst_n = 1'b1;
    wr(10'd5, 16'h1111, 1'b0, 1'b1, 1'b0, 1'b0, "R8 write quiet");
    @(negedge clk) rst_n = 1'b0;
    wr(10'd5, 16'h2222, 1'b0, 1'b1, 1'b0, 1'b0, "R1 write in reset quiet");
    @(negedge clk) rst_n = 1'b1;
    rd(10'd5, 1'b0, 1'b0, 1'b0, {2'b11, 16'h1111}, "R1 write blocked in reset");
  endtask

  task automatic t_standby();
    wr(10'd7, 16'hA55A, 1'b0, 1'b1, 1'b0, 1'b0, "R5 setup");
    @(negedge clk);
    addr = 10'd7; cs_n = 1'b1; oe_n = 1'b0; lbe_n = 1'b0; ube_n = 1'b0;
    #1 check("R2 standby float", {drv_hi, drv_lo, rdata}, 18'h0);
    idle();
    wr(10'd7, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, "R2 standby write quiet");
    rd(10'd7, 1'b0, 1'b0, 1'b0, {2'b11, 16'hA55A}, "R2 no write when deselected");
  endtask

  task automatic t_read_modes();
    wr(10'd9, 16'hBEEF, 1'b0, 1'b1, 1'b0, 1'b0, "R8 write quiet");
    rd(10'd9, 1'b0, 1'b0, 1'b0, {2'b11, 16'hBEEF}, "R4 full word");
    rd(10'd9, 1'b0, 1'b0, 1'b1, {2'b01, 16'h00EF}, "R4 lower only");
    rd(10'd9, 1'b0, 1'b1, 1'b0, {2'b10, 16'hBE00}, "R4 upper only");
    rd(10'd9, 1'b1, 1'b0, 1'b0, 18'h0, "R3 oe high float");
    rd(10'd9, 1'b0, 1'b1, 1'b1, 18'h0, "R3 no byte enable float");
  endtask

  task automatic t_byte_writes();
    wr(10'd12, 16'h1234, 1'b0, 1'b1, 1'b0, 1'b0, "R8 write quiet");
    wr(10'd13, 16'h5678, 1'b0, 1'b1, 1'b0, 1'b0, "R8 write quiet");
    wr(10'd12, 16'hABCD, 1'b0, 1'b1, 1'b0, 1'b1, "R8 write quiet");
    rd(10'd12, 1'b0, 1'b0, 1'b0, {2'b11, 16'h12CD}, "R6 upper kept on lower write");
    wr(10'd12, 16'hEF99, 1'b0, 1'b0, 1'b1, 1'b0, "R8 oe low write quiet");
    rd(10'd12, 1'b0, 1'b0, 1'b0, {2'b11, 16'hEFCD}, "R5 upper write with oe low");
    rd(10'd13, 1'b0, 1'b0, 1'b0, {2'b11, 16'h5678}, "R6 other address unchanged");
    wr(10'd13, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1, "R7 no strobe no drive");
    rd(10'd13, 1'b0, 1'b0, 1'b0, {2'b11, 16'h5678}, "R7 no write without byte enable");
    wr(10'd1023, 16'hC3C3, 1'b0, 1'b1, 1'b0, 1'b0, "R8 write quiet");
    rd(10'd1023, 1'b0, 1'b0, 1'b0, {2'b11, 16'hC3C3}, "R5 top address");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_standby();
    t_read_modes();
    t_byte_writes();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule